// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes the 16-bit data-memory address used by the operand-addressing modes of an 8-bit processor core. A mode code picks one of six ways to form the address: a full 16-bit immediate, a short form that places an 8-bit offset in a fixed 256-byte window, a peripheral-register form that places an 8-bit offset in the top page, indirection through either of two register pairs, and a based form that adds an unsigned 8-bit offset to one pair.

The short window runs from FE20H to FF1FH. It spans the top of internal RAM and the first 32 peripheral registers, so the page the offset lands in depends on the offset's value. The peripheral-register form covers the top page except a 16-byte reserved band at FFD0H to FFDFH. An offset that points into that band is flagged as illegal, and the address is not marked valid.

The block has no state. The address, the valid strobe and the illegal flag follow the inputs in the same cycle, and the core registers them as its pipeline needs.

Top module: `eag_addr_gen`

## Requirements
- R1: Mode code 1 (direct) drives addr_o with imm16_i unchanged, sets valid_o to 1 and illegal_o to 0. imm8_i has no effect.
- R2: Mode code 2 (short) with imm8_i in 20H..FFH drives addr_o = FE00H + imm8_i, with valid_o = 1 and illegal_o = 0.
- R3: Mode code 2 (short) with imm8_i in 00H..1FH drives addr_o = FF00H + imm8_i, with valid_o = 1 and illegal_o = 0.
- R4: Mode code 3 (peripheral register) with imm8_i outside D0H..DFH drives addr_o = FF00H + imm8_i, with valid_o = 1 and illegal_o = 0.
- R5: Mode code 3 with imm8_i in D0H..DFH sets illegal_o to 1 and valid_o to 0. valid_o and illegal_o are never both 1.
- R6: Mode code 4 drives addr_o with de_i and mode code 5 drives it with hl_i, with valid_o = 1, for any value of the pair.
- R7: Mode code 6 (based) drives addr_o = (hl_i + zero-extended imm8_i) mod 2^16, with valid_o = 1.
- R8: Mode codes 0 (none) and 7 (reserved) drive addr_o = 0, valid_o = 0 and illegal_o = 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 3 | Addressing mode code (0 none, 1 direct, 2 short, 3 peripheral register, 4 via DE, 5 via HL, 6 based, 7 reserved) |
| imm8_i | input | 8 | 8-bit offset from the instruction |
| imm16_i | input | 16 | 16-bit address from the instruction |
| de_i | input | 16 | Current DE pair value |
| hl_i | input | 16 | Current HL pair value |
| addr_o | output | 16 | Effective address |
| valid_o | output | 1 | Address is valid for the selected mode |
| illegal_o | output | 1 | Peripheral-register offset falls in the reserved band |

## Verification
Immediate assertions are evaluated whenever the outputs settle. They check the following on every evaluation: valid and illegal are never both high, a short-mode address always lies inside FE20H..FF1FH, a valid peripheral-register address stays in the top page and outside the reserved band, the based address minus HL equals the offset, and the none and reserved codes raise neither strobe. The exact placement of each short offset on its page, the exact edges of the reserved band, carry wrap in the based sum, and the fact that unselected inputs have no effect can only be shown by the bench. It sweeps every offset in every mode that takes one and compares the result with addresses it computes itself.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_NONE   = 3'd0,
    MODE_DIRECT = 3'd1,
    MODE_SHORT  = 3'd2,
    MODE_SFR    = 3'd3,
    MODE_IND_DE = 3'd4,
    MODE_IND_HL = 3'd5,
    MODE_BASED  = 3'd6,
    MODE_RSVD   = 3'd7
  } eag_mode_e;
endpackage

// File: rtl/eag_fixed_page.sv
// Places an offset on a fixed page: the short window splits between two pages,
// the peripheral-register page has a reserved band.
module eag_fixed_page #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter logic [ADDR_W-OFS_W-1:0] RAM_PAGE = 8'hFE,
  parameter logic [ADDR_W-OFS_W-1:0] REG_PAGE = 8'hFF,
  parameter logic [OFS_W-1:0] SPLIT   = 8'h20,
  parameter logic [OFS_W-1:0] HOLE_LO = 8'hD0,
  parameter logic [OFS_W-1:0] HOLE_HI = 8'hDF
) (
  input  logic              short_mode_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hole_o
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page;
  logic              in_band;

  assign page    = (short_mode_i && (ofs_i >= SPLIT)) ? RAM_PAGE : REG_PAGE;
  assign in_band = (ofs_i >= HOLE_LO) && (ofs_i <= HOLE_HI);
  assign addr_o  = {page, ofs_i};
  assign hole_o  = !short_mode_i && in_band;
endmodule

// File: rtl/eag_based_adder.sv
module eag_based_adder #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int PAD_W = ADDR_W - OFS_W;

  // offset is unsigned; carry out of the top bit is dropped
  assign sum_o = base_i + {{PAD_W{1'b0}}, ofs_i};
endmodule

// File: rtl/eag_addr_gen.sv
module eag_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter logic [ADDR_W-OFS_W-1:0] RAM_PAGE = 8'hFE,
  parameter logic [ADDR_W-OFS_W-1:0] REG_PAGE = 8'hFF,
  parameter logic [OFS_W-1:0] SPLIT   = 8'h20,
  parameter logic [OFS_W-1:0] HOLE_LO = 8'hD0,
  parameter logic [OFS_W-1:0] HOLE_HI = 8'hDF
) (
  input  logic [2:0]        mode_i,
  input  logic [OFS_W-1:0]  imm8_i,
  input  logic [ADDR_W-1:0] imm16_i,
  input  logic [ADDR_W-1:0] de_i,
  input  logic [ADDR_W-1:0] hl_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              illegal_o
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] SHORT_LO = {RAM_PAGE, SPLIT};
  localparam logic [ADDR_W-1:0] SHORT_HI = {REG_PAGE, SPLIT} - 1'b1;

  eag_mode_e         mode;
  logic [ADDR_W-1:0] page_addr;
  logic              page_hole;
  logic [ADDR_W-1:0] based_sum;

  assign mode = eag_mode_e'(mode_i);

  eag_fixed_page #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .RAM_PAGE(RAM_PAGE), .REG_PAGE(REG_PAGE),
    .SPLIT(SPLIT), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) u_page (
    .short_mode_i(mode == MODE_SHORT),
    .ofs_i       (imm8_i),
    .addr_o      (page_addr),
    .hole_o      (page_hole)
  );

  eag_based_adder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_based (
    .base_i(hl_i),
    .ofs_i (imm8_i),
    .sum_o (based_sum)
  );

  always_comb begin
    addr_o    = '0;
    valid_o   = 1'b0;
    illegal_o = 1'b0;
    unique case (mode)
      MODE_DIRECT: begin addr_o = imm16_i;   valid_o = 1'b1; end
      MODE_SHORT, MODE_SFR: begin
        addr_o    = page_addr;
        valid_o   = !page_hole;
        illegal_o = page_hole;
      end
      MODE_IND_DE: begin addr_o = de_i;      valid_o = 1'b1; end
      MODE_IND_HL: begin addr_o = hl_i;      valid_o = 1'b1; end
      MODE_BASED:  begin addr_o = based_sum; valid_o = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({mode_i, imm8_i, hl_i})) begin
      assert_excl_R5: assert (!(valid_o && illegal_o))
        else $error("valid and illegal both set");
      if (mode == MODE_SHORT) begin
        assert_short_window_R2: assert (valid_o && addr_o >= SHORT_LO && addr_o <= SHORT_HI)
          else $error("short address outside window");
      end
      if (mode == MODE_SFR && valid_o) begin
        assert_sfr_page_R4: assert (addr_o[ADDR_W-1:OFS_W] == REG_PAGE &&
                                    !(addr_o[OFS_W-1:0] >= HOLE_LO && addr_o[OFS_W-1:0] <= HOLE_HI))
          else $error("valid register address in reserved band");
      end
      if (mode == MODE_BASED) begin
        assert_based_offset_R7: assert (valid_o &&
                                        (addr_o - hl_i) == {{PAGE_W{1'b0}}, imm8_i})
          else $error("based address minus base differs from offset");
      end
      if (mode == MODE_NONE || mode == MODE_RSVD) begin
        assert_idle_quiet_R8: assert (!valid_o && !illegal_o)
          else $error("strobe raised in idle mode");
      end
    end
  end
endmodule

// File: tb/eag_addr_gen_test.sv
`timescale 1ns/1ps
module eag_addr_gen_test;
  logic        clk = 1'b0;
  logic [2:0]  mode;
  logic [7:0]  imm8;
  logic [15:0] imm16, de, hl;
  logic [15:0] addr;
  logic        valid, illegal;
  int          tests = 0;
  int          fails = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  eag_addr_gen uut (
    .mode_i(mode), .imm8_i(imm8), .imm16_i(imm16), .de_i(de), .hl_i(hl),
    .addr_o(addr), .valid_o(valid), .illegal_o(illegal)
  );

  task automatic apply(input logic [2:0] m, input logic [7:0] o8,
                       input logic [15:0] i16, input logic [15:0] d, input logic [15:0] h);
    @(posedge clk);
    mode = m; imm8 = o8; imm16 = i16; de = d; hl = h;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] ea, input logic ev, input logic ei);
    tests++;
    if (addr !== ea || valid !== ev || illegal !== ei) begin
      fails++;
      $display("FAIL %s mode=%0d ofs=%h: got addr=%h v=%b i=%b exp addr=%h v=%b i=%b",
               req, mode, imm8, addr, valid, illegal, ea, ev, ei);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] hl_set [5];
    hl_set = '{16'h0000, 16'h1234, 16'hFE20, 16'hFF80, 16'hFFFF};

    // R8: idle codes, first vector stands in for the power-up state
    for (int i = 0; i < 8; i++) begin
      apply((i % 2 == 0) ? 3'd0 : 3'd7, 8'(i * 37), 16'(i * 16'h1357), 16'hBEEF, 16'hCAFE);
      check("R8", 16'h0000, 1'b0, 1'b0);
    end

    // R1: direct, imm8 varied to show it is ignored
    for (int i = 0; i < 32; i++) begin
      logic [15:0] v = 16'(i * 16'h0841) ^ 16'hA5C3;
      apply(3'd1, 8'(255 - i), v, 16'h1111, 16'h2222);
      check("R1", v, 1'b1, 1'b0);
    end
    apply(3'd1, 8'hD5, 16'hFFFF, 16'h0, 16'h0); check("R1", 16'hFFFF, 1'b1, 1'b0);

    // R2/R3: short window, every offset
    for (int o = 0; o < 256; o++) begin
      apply(3'd2, 8'(o), 16'h4321, 16'h5555, 16'hAAAA);
      if (o >= 32) check("R2", 16'hFE00 + 16'(o), 1'b1, 1'b0);
      else         check("R3", 16'hFF00 + 16'(o), 1'b1, 1'b0);
    end

    // R4/R5: register page, every offset
    for (int o = 0; o < 256; o++) begin
      apply(3'd3, 8'(o), 16'h0F0F, 16'h1357, 16'h2468);
      if (o >= 8'hD0 && o <= 8'hDF) begin
        tests++;
        if (valid !== 1'b0 || illegal !== 1'b1) begin
          fails++;
          $display("FAIL R5 ofs=%h: got v=%b i=%b exp v=0 i=1", imm8, valid, illegal);
        end
      end else check("R4", 16'hFF00 + 16'(o), 1'b1, 1'b0);
    end

    // R6: indirect through each pair, other pair and immediates vary
    for (int i = 0; i < 24; i++) begin
      logic [15:0] p = 16'(i * 16'h2AB3) ^ 16'h8001;
      apply(3'd4, 8'(i), 16'h7777, p, ~p);
      check("R6", p, 1'b1, 1'b0);
      apply(3'd5, 8'(i), 16'h7777, ~p, p);
      check("R6", p, 1'b1, 1'b0);
    end

    // R7: based, includes carry wrap past FFFFH
    for (int b = 0; b < 5; b++) begin
      for (int o = 0; o < 256; o++) begin
        apply(3'd6, 8'(o), 16'h3C3C, 16'hDEAD, hl_set[b]);
        check("R7", 16'(32'(hl_set[b]) + o), 1'b1, 1'b0);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule